// File: doc/BRIEF.md
# Periodic Rate Generator

This block divides a 32.768 kHz reference, presented as a one-cycle enable strobe in the system clock domain, through a 15-stage binary chain. A 4-bit rate code picks one tap of that chain. The chosen tap drives a square-wave pin and sets a sticky periodic event flag on every rising edge. An interrupt request is raised while that flag is set and the interrupt is enabled.

The rate decode is irregular. Code 0 halts the output. Codes 3 to 15 step the rate down by a factor of two each, from 8192 Hz to 2 Hz. Codes 1 and 2 repeat the rates of codes 8 and 9. A bypass input puts the raw reference strobe on the pin instead and also blocks the periodic flag.

Software reads the flag through an 8-bit status byte and clears it by reading. A one-cycle read strobe marks the read. A new rate code is taken up only when the current tap falls, so the pin never shows a runt pulse. There is no streaming data path: every pin is a plain level or strobe.

Top module: `pulse_rate_gen`

## Requirements
- R1: While reset is held, wave_out, per_flag and irq_req are 0 and stat_byte reads 8'h00.
- R2: For a rate code c from 3 to 15, with the bypass low and the wave enable high, wave_out rises once every 2^(c-1) reference strobes (code 3: 4 strobes, code 9: 256, code 15: 16384).
- R3: Code 1 gives the same period as code 8 (128 strobes), and code 2 gives the same period as code 9 (256 strobes).
- R4: When code 0 is in effect, wave_out stays 0 and per_flag never sets.
- R5: While raw_ovr is 1 and wave_en is 1, wave_out is ref_tick delayed by one clock, whatever the rate code, so it rises once per reference strobe.
- R6: While raw_ovr is 1, per_flag is never set.
- R7: A clock edge at which wave_en is 0 leaves wave_out at 0. The periodic flag keeps running regardless.
- R8: per_flag becomes 1 the clock after each rising edge of the active tap. A stat_rd strobe clears it at the next edge. If a set and a read fall on the same edge, the set wins.
- R9: irq_req is 1 exactly when per_flag and per_irq_en are both 1. stat_byte has irq_req in bit 7 and per_flag in bit 6. Bits 5 to 0 read 0.
- R10: A changed rate code takes effect in the cycle the active tap falls, or at once when code 0 is active. The first rising edge after the change is already at the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_sel | input | 4 | Requested rate code |
| wave_en | input | 1 | Square-wave pin enable |
| raw_ovr | input | 1 | Put the raw reference on the pin and block periodic events |
| per_irq_en | input | 1 | Periodic interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears the periodic flag |
| wave_out | output | 1 | Square-wave pin |
| per_flag | output | 1 | Sticky periodic event flag |
| irq_req | output | 1 | Interrupt request |
| stat_byte | output | 8 | Status byte: bit 7 irq_req, bit 6 per_flag |

## Verification
Some rules hold cycle by cycle, and the assertions check those on every edge:
- the pin is silent after a disabled cycle;
- a read clears the flag, and a tap rise sets it;
- the bypass keeps the flag clear;
- a halted code raises no event;
- the active code changes only while the old tap is low.

The period each code produces, the aliasing of codes 1 and 2, the strobe-rate bypass output and a clean first period after a code change all depend on long tap sequences. Only the bench scenarios can show those, by counting reference strobes between rising edges of the pin.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int RATE_W     = 4;
  localparam int TAP_W      = 4;
  localparam int DIV_STAGES = 15;

  // aliased codes map onto the taps of these codes
  localparam logic [RATE_W-1:0] ALIAS_A_SRC = 4'd1;
  localparam logic [RATE_W-1:0] ALIAS_A_DST = 4'd8;
  localparam logic [RATE_W-1:0] ALIAS_B_SRC = 4'd2;
  localparam logic [RATE_W-1:0] ALIAS_B_DST = 4'd9;
  localparam logic [RATE_W-1:0] HALT_CODE   = 4'd0;
  localparam logic [RATE_W-1:0] TAP_OFFSET  = 4'd2;

  typedef struct packed {
    logic             run;
    logic [TAP_W-1:0] idx;
  } tap_sel_t;

  function automatic tap_sel_t decode_rate(input logic [RATE_W-1:0] code);
    tap_sel_t             s;
    logic [RATE_W-1:0]    eff;
    eff = code;
    if (code == ALIAS_A_SRC) eff = ALIAS_A_DST;
    if (code == ALIAS_B_SRC) eff = ALIAS_B_DST;
    s.run = (code != HALT_CODE);
    s.idx = s.run ? TAP_W'(eff - TAP_OFFSET) : '0;
    return s;
  endfunction
endpackage

// File: rtl/prg_divider.sv
module prg_divider #(
  parameter int STAGES = prg_pkg::DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [STAGES-1:0] chain
);
  logic [STAGES:0]   carry;
  logic [STAGES-1:0] q;

  assign carry[0] = adv;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign carry[k+1] = carry[k] & q[k];
    always_ff @(posedge clk) begin
      if (!rst_n) q[k] <= 1'b0;
      else        q[k] <= q[k] ^ carry[k];
    end
  end

  assign chain = q;
endmodule

// File: rtl/prg_tap_select.sv
module prg_tap_select
  import prg_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] chain,
  input  logic [RATE_W-1:0] code_req,
  output logic [RATE_W-1:0] act_code,
  output logic              tap_lvl,
  output logic              tap_rise
);
  tap_sel_t cur_sel, nxt_sel;
  logic     nxt_lvl, lvl_q, swap;

  assign cur_sel = decode_rate(act_code);
  assign nxt_sel = decode_rate(code_req);

  always_comb begin
    tap_lvl = 1'b0;
    if (cur_sel.run && (int'(cur_sel.idx) < STAGES)) tap_lvl = chain[cur_sel.idx];
    nxt_lvl = 1'b0;
    if (nxt_sel.run && (int'(nxt_sel.idx) < STAGES)) nxt_lvl = chain[nxt_sel.idx];
  end

  // adopt a new code only while the active tap has just fallen, or when halted
  assign swap     = (lvl_q & ~tap_lvl) | ~cur_sel.run;
  assign tap_rise = cur_sel.run & tap_lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_code <= HALT_CODE;
      lvl_q    <= 1'b0;
    end else if (swap) begin
      act_code <= code_req;
      lvl_q    <= nxt_lvl;
    end else begin
      lvl_q    <= tap_lvl;
    end
  end
endmodule

// File: rtl/prg_flag.sv
module prg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/pulse_rate_gen.sv
module pulse_rate_gen
  import prg_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              wave_en,
  input  logic              raw_ovr,
  input  logic              per_irq_en,
  input  logic              stat_rd,
  output logic              wave_out,
  output logic              per_flag,
  output logic              irq_req,
  output logic [7:0]        stat_byte
);
  logic [STAGES-1:0] chain;
  logic [RATE_W-1:0] act_code;
  logic              tap_lvl, tap_rise, set_evt, wave_q;

  prg_divider #(.STAGES(STAGES)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ref_tick),
    .chain (chain)
  );

  prg_tap_select #(.STAGES(STAGES)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .chain    (chain),
    .code_req (rate_sel),
    .act_code (act_code),
    .tap_lvl  (tap_lvl),
    .tap_rise (tap_rise)
  );

  assign set_evt = tap_rise & ~raw_ovr;

  prg_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr     (stat_rd),
    .irq_en  (per_irq_en),
    .flag    (per_flag),
    .irq     (irq_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_en & (raw_ovr ? ref_tick : tap_lvl);
  end

  assign wave_out  = wave_q;
  assign stat_byte = {irq_req, per_flag, 6'b0};
endmodule

// File: rtl/prg_checker.sv
module prg_checker
  import prg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wave_en,
  input logic              wave_out,
  input logic              stat_rd,
  input logic              per_flag,
  input logic              raw_ovr,
  input logic              set_evt,
  input logic [RATE_W-1:0] act_code,
  input logic              tap_lvl
);
  // R7
  wave_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_en |=> !wave_out);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !set_evt |=> !per_flag);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> per_flag);

  // R6
  ovr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_ovr && !per_flag |=> !per_flag);

  // R4
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_code == HALT_CODE |-> !set_evt);

  // R10
  swap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code != $past(act_code)) && ($past(act_code) != HALT_CODE) |-> !$past(tap_lvl));
endmodule

bind pulse_rate_gen prg_checker u_prg_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wave_en  (wave_en),
  .wave_out (wave_out),
  .stat_rd  (stat_rd),
  .per_flag (per_flag),
  .raw_ovr  (raw_ovr),
  .set_evt  (set_evt),
  .act_code (act_code),
  .tap_lvl  (tap_lvl)
);

// File: tb/pulse_rate_gen_bench.sv
`timescale 1ns/1ps
module pulse_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [3:0] rate_sel = 4'd3;
  logic       wave_en = 1'b1;
  logic       raw_ovr = 1'b0;
  logic       per_irq_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic       wave_out, per_flag, irq_req;
  logic [7:0] stat_byte;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int last_rise = 0;
  bit have_last = 0;
  bit mon_arm = 0;
  bit prev_w = 0;
  bit wave_seen_hi = 0;
  int prev_tap = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pulse_rate_gen u_pulse_rate_gen (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_sel(rate_sel),
    .wave_en(wave_en), .raw_ovr(raw_ovr), .per_irq_en(per_irq_en),
    .stat_rd(stat_rd), .wave_out(wave_out), .per_flag(per_flag),
    .irq_req(irq_req), .stat_byte(stat_byte)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference strobe: one clock high out of every two
  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk); #1 ref_tick = 1'b1; tick_cnt++;
      @(posedge clk); #1 ref_tick = 1'b0;
    end
  end

  // monitor: measures strobes between rising edges of the pin
  initial begin
    forever begin
      @(negedge clk);
      if (wave_out) wave_seen_hi = 1'b1;
      if (wave_out && !prev_w && mon_arm) begin
        if (have_last && exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check((tick_cnt - last_rise) == e, t, tick_cnt - last_rise, e);
        end
        last_rise = tick_cnt;
        have_last = 1'b1;
      end
      prev_w = wave_out;
    end
  end

  task automatic wait_ticks(input int n);
    int start;
    start = tick_cnt;
    wait (tick_cnt >= start + n);
  endtask

  // driver: apply a code, let it settle, queue the expected period
  task automatic measure(input logic [3:0] code, input int exp, input string tag);
    mon_arm = 1'b0;
    rate_sel = code;
    wait_ticks(prev_tap + 2);
    have_last = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    mon_arm = 1'b1;
    wait (exp_q.size() == 0);
    mon_arm = 1'b0;
    prev_tap = exp;
  endtask

  task automatic read_status();
    @(posedge clk); #1 stat_rd = 1'b1;
    @(posedge clk); #1 stat_rd = 1'b0;
  endtask

  task automatic wait_flag();
    do @(negedge clk); while (!per_flag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary_and_end();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(wave_out == 1'b0, "R1", wave_out, 0);
    check(per_flag == 1'b0, "R1", per_flag, 0);
    check(irq_req == 1'b0, "R1", irq_req, 0);
    check(stat_byte == 8'h00, "R1", stat_byte, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2, R3, R10 periods
    measure(4'd3, 4, "R2");
    measure(4'd4, 8, "R10");
    measure(4'd6, 32, "R2");
    measure(4'd8, 128, "R2");
    measure(4'd1, 128, "R3");
    measure(4'd2, 256, "R3");
    measure(4'd9, 256, "R2");

    // R8, R9 flag, read clear, irq
    read_status();
    per_irq_en = 1'b1;
    wait_flag();
    check(irq_req == 1'b1, "R9", irq_req, 1);
    check(stat_byte == 8'hC0, "R9", stat_byte, 8'hC0);
    read_status();
    @(negedge clk);
    check(per_flag == 1'b0, "R8", per_flag, 0);
    per_irq_en = 1'b0;
    wait_flag();
    check(irq_req == 1'b0, "R9", irq_req, 0);
    check(stat_byte == 8'h40, "R9", stat_byte, 8'h40);

    // R7 pin disabled, flag keeps running
    read_status();
    wave_en = 1'b0;
    @(negedge clk); @(negedge clk);
    wave_seen_hi = 1'b0;
    wait_ticks(600);
    check(wave_seen_hi == 1'b0, "R7", wave_seen_hi, 0);
    check(per_flag == 1'b1, "R7", per_flag, 1);
    wave_en = 1'b1;

    // R4 halt code
    rate_sel = 4'd0;
    wait_ticks(prev_tap + 4);
    read_status();
    @(negedge clk);
    wave_seen_hi = 1'b0;
    wait_ticks(400);
    check(wave_seen_hi == 1'b0, "R4", wave_seen_hi, 0);
    check(per_flag == 1'b0, "R4", per_flag, 0);
    prev_tap = 0;

    // R10 immediate adoption from halt
    measure(4'd5, 16, "R10");

    // R5, R6 bypass
    raw_ovr = 1'b1;
    read_status();
    @(negedge clk);
    wait_ticks(100);
    check(per_flag == 1'b0, "R6", per_flag, 0);
    measure(4'd5, 1, "R5");
    raw_ovr = 1'b0;
    prev_tap = 16;

    // R2 slowest rate
    measure(4'd15, 16384, "R2");

    summary_and_end();
  end
endmodule